// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a byte-wide host bus and the operation sequencer of a flash device. It watches chip enable and write enable, and each time a write cycle ends it takes the byte that was on the data bus as a command. Most commands take one cycle. Some are two-cycle pairs: a setup byte followed by a confirm byte or by the data to program. The decoder keeps track of which read source the next bus read should return (array, identifier codes or status). It issues a launch strobe for erase, program and lock operations, together with the captured address and data. It also issues suspend and resume requests to the sequencer, a strobe that clears the status register, and a strobe that reports a bad command sequence.

Which commands are accepted depends on the state that the sequencer reports. It may be idle, running, running with an erase suspended, or running with a program suspended. A command that is not allowed in the current state, and any code the decoder does not know, is dropped with no side effect. When an operation is launched, the read source changes to status so that the host can poll the result.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, readMode is 0 (0 = array, 1 = identifier, 2 = status), no setup is pending and every strobe output is low.
- R2: When idle, the codes FFh, 90h and 70h set readMode to 0, 1 and 2. An unknown code (for example 33h) leaves readMode unchanged and raises no strobe.
- R3: A write cycle is the span in which ceN and weN are both low. It ends at the first clock that samples either of them high. The address and data it carries are those present at the last clock that sampled both low. Its result appears on the outputs one clock after the end is sampled.
- R4: 20h followed by D0h launches an erase: opStrobe pulses for one clock with opKind 1, opAddr is the address of the confirm cycle, and readMode becomes 2.
- R5: 40h or 10h followed by any byte launches a program: opKind 2, with opAddr and opData taken from the second cycle. readMode becomes 2.
- R6: 60h followed by 01h, F1h or D0h launches opKind 3 (lock one block), 4 (set the master lock) or 5 (clear all block locks). readMode becomes 2.
- R7: After 20h or 60h, a confirm byte that is not valid pulses badSeq, launches nothing and sets readMode to 2. At most one strobe output is high in any clock.
- R8: While seqBusy is high and nothing is suspended, only 70h and B0h are accepted. B0h pulses suspendReq and sets readMode to 2. FFh, 90h and setup codes are ignored.
- R9: While writeSusp is high, only FFh, 70h and D0h are accepted. D0h pulses resumeReq and sets readMode to 2.
- R10: While eraseSusp is high (and writeSusp is low), FFh, 70h, 90h, D0h and the program setup (40h/10h) are accepted. Erase and lock setups are ignored.
- R11: 50h pulses clearStatus when the sequencer is idle and leaves readMode unchanged. It is ignored while anything is suspended.
- R12: A pending setup is consumed by exactly the next write cycle, whatever that cycle's byte is. Reset discards a pending setup.
- R13: dataOutEn is high exactly while ceN and oeN are low and weN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addrIn | input | ADDR_W | Bus address |
| dataIn | input | DATA_W | Bus write data; the command is in bits 7:0 |
| seqBusy | input | 1 | Sequencer has an operation in progress |
| eraseSusp | input | 1 | An erase is suspended |
| writeSusp | input | 1 | A program is suspended |
| readMode | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| dataOutEn | output | 1 | Drive read data onto the bus |
| opStrobe | output | 1 | One-clock launch strobe |
| opKind | output | 3 | Launched operation, 0 when no launch |
| opAddr | output | ADDR_W | Address of the last launch |
| opData | output | DATA_W | Data of the last launch |
| suspendReq | output | 1 | Request to suspend the running operation |
| resumeReq | output | 1 | Request to resume the suspended operation |
| clearStatus | output | 1 | Clear the status error bits |
| badSeq | output | 1 | Bad confirm byte; sets the sequence error bits |

## Verification
The bench targets the cases where the sequencer state changes whether a code is accepted. Read-array while running must be dropped; a design that took it would hand array data to a host that is polling status. Clear-status while suspended must be dropped; a design that took it would erase the error history of the suspended job. A setup byte must be consumed by the very next cycle: a design that kept it, or that kept it across reset, would launch an erase from a stray D0h. Writes ended by chip enable instead of write enable, and confirm bytes that are not valid, are checked for a missing or wrong launch and for badSeq firing at the wrong time.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2
  } readMode_e;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_ERASE = 2'd1,
    PEND_WRITE = 2'd2,
    PEND_LOCK  = 2'd3
  } pend_e;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_ERASE   = 3'd1,
    OP_WRITE   = 3'd2,
    OP_BLKLOCK = 3'd3,
    OP_MSTLOCK = 3'd4,
    OP_CLRLOCK = 3'd5
  } opKind_e;

  typedef enum logic [1:0] {
    CTX_IDLE  = 2'd0,
    CTX_BUSY  = 2'd1,
    CTX_ESUSP = 2'd2,
    CTX_WSUSP = 2'd3
  } seqCtx_e;

  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_RD_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
  localparam logic [7:0] CMD_ERASE_SET = 8'h20;
  localparam logic [7:0] CMD_WRITE_SET = 8'h40;
  localparam logic [7:0] CMD_WRITE_ALT = 8'h10;
  localparam logic [7:0] CMD_LOCK_SET  = 8'h60;
  localparam logic [7:0] CMD_SUSPEND   = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
  localparam logic [7:0] CMD_LOCK_BLK  = 8'h01;
  localparam logic [7:0] CMD_LOCK_MST  = 8'hF1;

  typedef struct packed {
    logic loadOp;
  } ctrlStb_t;

endpackage

// File: rtl/fcd_busport.sv
module fcd_busport
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStb_t          stb,
  output logic              cycleDone,
  output logic [7:0]        cmdByte,
  output logic              dataOutEn,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData
);

  localparam int CMD_W = 8;

  logic              writeActive;
  logic              activeQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  assign writeActive = !ceN && !weN;
  assign cycleDone   = activeQ && !writeActive;
  assign cmdByte     = dataQ[CMD_W-1:0];
  assign dataOutEn   = !ceN && !oeN && weN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      addrQ   <= '0;
      dataQ   <= '0;
      opAddr  <= '0;
      opData  <= '0;
    end else begin
      activeQ <= writeActive;
      if (writeActive) begin
        addrQ <= addrIn;
        dataQ <= dataIn;
      end
      if (stb.loadOp) begin
        opAddr <= addrQ;
        opData <= dataQ;
      end
    end
  end

  assert_single_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

  assert_load_on_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadOp |-> cycleDone);

endmodule

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleDone,
  input  logic [7:0] cmdByte,
  input  logic       seqBusy,
  input  logic       eraseSusp,
  input  logic       writeSusp,
  output ctrlStb_t   stb,
  output logic [1:0] readMode,
  output logic       opStrobe,
  output logic [2:0] opKind,
  output logic       suspendReq,
  output logic       resumeReq,
  output logic       clearStatus,
  output logic       badSeq
);

  pend_e     pend, pendNext;
  readMode_e mode, modeNext;
  opKind_e   kindNext;
  seqCtx_e   ctx;
  logic      launch, suspNext, resNext, clrNext, badNext;
  logic      okArray, okIdent, okClear, okErase, okWrite, okLock, okSusp, okRes;

  always_comb begin
    if (writeSusp)      ctx = CTX_WSUSP;
    else if (eraseSusp) ctx = CTX_ESUSP;
    else if (seqBusy)   ctx = CTX_BUSY;
    else                ctx = CTX_IDLE;
  end

  assign okArray = (ctx != CTX_BUSY);
  assign okIdent = (ctx == CTX_IDLE) || (ctx == CTX_ESUSP);
  assign okClear = (ctx == CTX_IDLE);
  assign okErase = (ctx == CTX_IDLE);
  assign okWrite = (ctx == CTX_IDLE) || (ctx == CTX_ESUSP);
  assign okLock  = (ctx == CTX_IDLE);
  assign okSusp  = (ctx == CTX_BUSY);
  assign okRes   = (ctx == CTX_ESUSP) || (ctx == CTX_WSUSP);

  always_comb begin
    pendNext = pend;
    modeNext = mode;
    kindNext = OP_NONE;
    launch   = 1'b0;
    suspNext = 1'b0;
    resNext  = 1'b0;
    clrNext  = 1'b0;
    badNext  = 1'b0;
    if (cycleDone) begin
      if (pend != PEND_NONE) begin
        pendNext = PEND_NONE;
        modeNext = RM_STATUS;
        case (pend)
          PEND_WRITE: begin
            launch   = 1'b1;
            kindNext = OP_WRITE;
          end
          PEND_ERASE: begin
            if (cmdByte == CMD_CONFIRM) begin
              launch   = 1'b1;
              kindNext = OP_ERASE;
            end else begin
              badNext = 1'b1;
            end
          end
          PEND_LOCK: begin
            case (cmdByte)
              CMD_LOCK_BLK: begin launch = 1'b1; kindNext = OP_BLKLOCK; end
              CMD_LOCK_MST: begin launch = 1'b1; kindNext = OP_MSTLOCK; end
              CMD_CONFIRM:  begin launch = 1'b1; kindNext = OP_CLRLOCK; end
              default:      badNext = 1'b1;
            endcase
          end
          default: ;
        endcase
      end else begin
        case (cmdByte)
          CMD_RD_ARRAY:  if (okArray) modeNext = RM_ARRAY;
          CMD_RD_IDENT:  if (okIdent) modeNext = RM_IDENT;
          CMD_RD_STATUS: modeNext = RM_STATUS;
          CMD_CLR_STAT:  if (okClear) clrNext = 1'b1;
          CMD_ERASE_SET: if (okErase) pendNext = PEND_ERASE;
          CMD_WRITE_SET,
          CMD_WRITE_ALT: if (okWrite) pendNext = PEND_WRITE;
          CMD_LOCK_SET:  if (okLock) pendNext = PEND_LOCK;
          CMD_SUSPEND: begin
            if (okSusp) begin
              suspNext = 1'b1;
              modeNext = RM_STATUS;
            end
          end
          CMD_CONFIRM: begin
            if (okRes) begin
              resNext  = 1'b1;
              modeNext = RM_STATUS;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign stb.loadOp = launch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend        <= PEND_NONE;
      mode        <= RM_ARRAY;
      opStrobe    <= 1'b0;
      opKind      <= OP_NONE;
      suspendReq  <= 1'b0;
      resumeReq   <= 1'b0;
      clearStatus <= 1'b0;
      badSeq      <= 1'b0;
    end else begin
      pend        <= pendNext;
      mode        <= modeNext;
      opStrobe    <= launch;
      opKind      <= kindNext;
      suspendReq  <= suspNext;
      resumeReq   <= resNext;
      clearStatus <= clrNext;
      badSeq      <= badNext;
    end
  end

  assign readMode = mode;

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({opStrobe, suspendReq, resumeReq, clearStatus, badSeq}));

  assert_launch_status_R4: assert property (@(posedge clk) disable iff (!rstN)
    opStrobe |-> (readMode == RM_STATUS && opKind != OP_NONE));

  assert_bad_no_launch_R7: assert property (@(posedge clk) disable iff (!rstN)
    badSeq |-> (readMode == RM_STATUS && opKind == OP_NONE));

  assert_clear_keeps_mode_R11: assert property (@(posedge clk) disable iff (!rstN)
    clearStatus |-> $stable(readMode));

  assert_resume_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    resumeReq |-> (readMode == RM_STATUS && $past(eraseSusp || writeSusp)));

  assert_suspend_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    suspendReq |-> $past(seqBusy && !eraseSusp && !writeSusp));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              seqBusy,
  input  logic              eraseSusp,
  input  logic              writeSusp,
  output logic [1:0]        readMode,
  output logic              dataOutEn,
  output logic              opStrobe,
  output logic [2:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic              suspendReq,
  output logic              resumeReq,
  output logic              clearStatus,
  output logic              badSeq
);

  ctrlStb_t   stb;
  logic       cycleDone;
  logic [7:0] cmdByte;

  fcd_busport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) busport_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addrIn(addrIn), .dataIn(dataIn), .stb(stb),
    .cycleDone(cycleDone), .cmdByte(cmdByte), .dataOutEn(dataOutEn),
    .opAddr(opAddr), .opData(opData)
  );

  fcd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cycleDone(cycleDone), .cmdByte(cmdByte),
    .seqBusy(seqBusy), .eraseSusp(eraseSusp), .writeSusp(writeSusp),
    .stb(stb), .readMode(readMode), .opStrobe(opStrobe), .opKind(opKind),
    .suspendReq(suspendReq), .resumeReq(resumeReq),
    .clearStatus(clearStatus), .badSeq(badSeq)
  );

endmodule

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [19:0] addrIn = '0;
  logic [7:0]  dataIn = '0;
  logic        seqBusy = 1'b0, eraseSusp = 1'b0, writeSusp = 1'b0;
  logic [1:0]  readMode;
  logic        dataOutEn, opStrobe, suspendReq, resumeReq, clearStatus, badSeq;
  logic [2:0]  opKind;
  logic [19:0] opAddr;
  logic [7:0]  opData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(20), .DATA_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addrIn(addrIn), .dataIn(dataIn), .seqBusy(seqBusy),
    .eraseSusp(eraseSusp), .writeSusp(writeSusp), .readMode(readMode),
    .dataOutEn(dataOutEn), .opStrobe(opStrobe), .opKind(opKind),
    .opAddr(opAddr), .opData(opData), .suspendReq(suspendReq),
    .resumeReq(resumeReq), .clearStatus(clearStatus), .badSeq(badSeq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int mMode = 0, mPend = 0, mAddr = 0, mData = 0;
  bit mPrev = 0;
  int eKind, eAddr = 0, eData = 0;
  bit eStrobe, eSusp, eRes, eClr, eBad;

  task automatic launchOp(input int k, input int a, input int d);
    eStrobe = 1; eKind = k; eAddr = a; eData = d;
  endtask

  task automatic modelEvent(input int d, input int a, input int ctx);
    int c;
    c = d & 255;
    if (mPend == 1) begin
      mPend = 0; mMode = 2;
      if (c == 208) launchOp(1, a, d); else eBad = 1;
    end else if (mPend == 2) begin
      mPend = 0; mMode = 2; launchOp(2, a, d);
    end else if (mPend == 3) begin
      mPend = 0; mMode = 2;
      if (c == 1) launchOp(3, a, d);
      else if (c == 241) launchOp(4, a, d);
      else if (c == 208) launchOp(5, a, d);
      else eBad = 1;
    end else begin
      case (c)
        255: if (ctx != 1) mMode = 0;
        144: if (ctx == 0 || ctx == 2) mMode = 1;
        112: mMode = 2;
        80:  if (ctx == 0) eClr = 1;
        32:  if (ctx == 0) mPend = 1;
        64, 16: if (ctx == 0 || ctx == 2) mPend = 2;
        96:  if (ctx == 0) mPend = 3;
        176: if (ctx == 1) begin eSusp = 1; mMode = 2; end
        208: if (ctx >= 2) begin eRes = 1; mMode = 2; end
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    bit act;
    int ctx;
    act = !ceN && !weN;
    ctx = writeSusp ? 3 : eraseSusp ? 2 : seqBusy ? 1 : 0;
    eStrobe = 0; eKind = 0; eSusp = 0; eRes = 0; eClr = 0; eBad = 0;
    if (!rstN) begin
      mMode = 0; mPend = 0; mPrev = 0; eAddr = 0; eData = 0;
    end else begin
      if (mPrev && !act) modelEvent(mData, mAddr, ctx);
      if (act) begin mAddr = int'(addrIn); mData = int'(dataIn); end
      mPrev = act;
    end
    #2;
    if (!done) begin
      chk(int'(readMode) == mMode, "R2 readMode", readMode, mMode);
      chk(opStrobe == eStrobe, "R4 opStrobe", opStrobe, eStrobe);
      chk(int'(opKind) == eKind, "R6 opKind", opKind, eKind);
      chk(int'(opAddr) == eAddr, "R5 opAddr", opAddr, eAddr);
      chk(int'(opData) == eData, "R5 opData", opData, eData);
      chk(suspendReq == eSusp, "R8 suspendReq", suspendReq, eSusp);
      chk(resumeReq == eRes, "R9 resumeReq", resumeReq, eRes);
      chk(clearStatus == eClr, "R11 clearStatus", clearStatus, eClr);
      chk(badSeq == eBad, "R7 badSeq", badSeq, eBad);
      chk(dataOutEn == (!ceN && !oeN && weN), "R13 dataOutEn", dataOutEn, !ceN && !oeN && weN);
    end
  end

  // bus write; returns right after the clock that shows its result
  task automatic wr(input logic [19:0] a, input logic [7:0] d, input bit ceCtl);
    @(negedge clk); addrIn = a; dataIn = d; ceN = 0; weN = 0;
    @(negedge clk); if (ceCtl) ceN = 1; else weN = 1;
    addrIn = a ^ 20'h00F0F; dataIn = ~d;
    @(posedge clk); #3;
    ceN = 1; weN = 1;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    @(negedge clk);
    @(negedge clk); rstN = 1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(posedge clk); #3;
    chk(readMode == 2'd0 && !opStrobe && !badSeq, "R1 reset state", readMode, 0);

    // R2 read mode selection
    wr(20'h00010, 8'h90, 0); chk(readMode == 2'd1, "R2 ident", readMode, 1);
    wr(20'h00010, 8'h33, 0); chk(readMode == 2'd1, "R2 unknown kept", readMode, 1);
    wr(20'h00010, 8'h70, 0); chk(readMode == 2'd2, "R2 status", readMode, 2);
    wr(20'h00010, 8'hFF, 1); chk(readMode == 2'd0, "R2 array", readMode, 0);

    // R4 erase with a chip-enable-ended confirm (R3)
    wr(20'h35000, 8'h20, 0);
    wr(20'h35010, 8'hD0, 1);
    chk(opStrobe && opKind == 3'd1, "R4 erase launch", opKind, 1);
    chk(opAddr == 20'h35010, "R3 captured address", opAddr, 20'h35010);
    chk(readMode == 2'd2, "R4 status after launch", readMode, 2);

    // R5 program, both setup codes
    wr(20'h00000, 8'h40, 0); wr(20'h12345, 8'hA5, 0);
    chk(opStrobe && opKind == 3'd2 && opData == 8'hA5, "R5 write launch", opData, 8'hA5);
    wr(20'h00000, 8'h10, 1); wr(20'h0ABCD, 8'h3C, 1);
    chk(opStrobe && opAddr == 20'h0ABCD && opData == 8'h3C, "R5 alt setup", opAddr, 20'h0ABCD);

    // R6 lock commands
    wr(20'h20000, 8'h60, 0); wr(20'h20000, 8'h01, 0);
    chk(opKind == 3'd3, "R6 block lock", opKind, 3);
    wr(20'h20000, 8'h60, 0); wr(20'h20000, 8'hF1, 0);
    chk(opKind == 3'd4, "R6 master lock", opKind, 4);
    wr(20'h20000, 8'h60, 0); wr(20'h20000, 8'hD0, 0);
    chk(opKind == 3'd5, "R6 clear locks", opKind, 5);

    // R7 bad confirms, R12 setup consumed
    wr(20'h00000, 8'hFF, 0);
    wr(20'h40000, 8'h20, 0); wr(20'h40000, 8'hFF, 0);
    chk(badSeq && !opStrobe && readMode == 2'd2, "R7 erase bad confirm", badSeq, 1);
    wr(20'h40000, 8'hFF, 0);
    chk(readMode == 2'd0 && !badSeq, "R12 setup consumed", readMode, 0);
    wr(20'h40000, 8'h60, 0); wr(20'h40000, 8'h77, 0);
    chk(badSeq && opKind == 3'd0, "R7 lock bad confirm", badSeq, 1);

    // R11 clear status when idle
    wr(20'h0, 8'hFF, 0);
    wr(20'h0, 8'h50, 0);
    chk(clearStatus && readMode == 2'd0, "R11 clear idle", clearStatus, 1);

    // R8 busy
    wr(20'h0, 8'h70, 0);
    @(negedge clk); seqBusy = 1;
    wr(20'h0, 8'hFF, 0); chk(readMode == 2'd2, "R8 array ignored", readMode, 2);
    wr(20'h0, 8'h90, 0); chk(readMode == 2'd2, "R8 ident ignored", readMode, 2);
    wr(20'h50000, 8'h20, 0); wr(20'h50000, 8'hD0, 0);
    chk(!opStrobe && !resumeReq, "R8 setup ignored", opStrobe, 0);
    wr(20'h0, 8'hB0, 0); chk(suspendReq, "R8 suspend", suspendReq, 1);

    // R9 program suspended
    @(negedge clk); writeSusp = 1;
    wr(20'h0, 8'h90, 0); chk(readMode == 2'd2, "R9 ident ignored", readMode, 2);
    wr(20'h0, 8'h50, 0); chk(!clearStatus, "R11 clear ignored in suspend", clearStatus, 0);
    wr(20'h0, 8'hFF, 0); chk(readMode == 2'd0, "R9 array in suspend", readMode, 0);
    wr(20'h0, 8'hD0, 0); chk(resumeReq && readMode == 2'd2, "R9 resume", resumeReq, 1);

    // R10 erase suspended
    @(negedge clk); writeSusp = 0; eraseSusp = 1;
    wr(20'h0, 8'h90, 0); chk(readMode == 2'd1, "R10 ident in erase suspend", readMode, 1);
    wr(20'h0, 8'h50, 0); chk(!clearStatus, "R11 clear ignored in erase suspend", clearStatus, 0);
    wr(20'h0, 8'h40, 0); wr(20'h61234, 8'h5A, 0);
    chk(opStrobe && opKind == 3'd2, "R10 write in erase suspend", opKind, 2);
    wr(20'h0, 8'h20, 0); wr(20'h0, 8'hFF, 0);
    chk(readMode == 2'd0 && !badSeq, "R10 erase setup ignored", readMode, 0);
    wr(20'h0, 8'hD0, 0); chk(resumeReq, "R10 resume", resumeReq, 1);
    @(negedge clk); eraseSusp = 0; seqBusy = 0;

    // R12 reset drops pending; setup held for one cycle only
    wr(20'h0, 8'h20, 0);
    doReset();
    wr(20'h0, 8'hD0, 0);
    chk(!opStrobe && readMode == 2'd0, "R12 reset clears setup", opStrobe, 0);
    wr(20'h0, 8'h40, 0); wr(20'h00011, 8'h11, 0);
    wr(20'h0, 8'hD0, 0);
    chk(!opStrobe, "R12 no second launch", opStrobe, 0);

    // R13 output enable
    @(negedge clk); ceN = 0; oeN = 0;
    #1 chk(dataOutEn, "R13 read enable", dataOutEn, 1);
    @(negedge clk); weN = 0;
    #1 chk(!dataOutEn, "R13 off during write", dataOutEn, 0);
    @(negedge clk); ceN = 1; oeN = 1; weN = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule